// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-port synchronous static memory with registered address and control inputs, a one-stage read pipeline and an internal two-bit burst counter. One presented address can yield up to four data words. The first is at the presented address. The next three come from the counter, in either linear or interleaved order, chosen by a static pin. Writes are late writes: the address, data and byte controls are captured on one clock edge, and the array is updated on the following edge.

A new access begins when either of two start strobes is sampled active. One strobe is meant for a processor and the other for a cache controller. The chip is selected only when the chip enable and both chip selects are active. A start seen while the chip is unselected closes the current access, and the output-drive flag drops one cycle later. Output enable and the sleep input act without the clock. Data in and data out are separate ports, and a drive flag takes the place of a three-state bus. The word is built from byte lanes, each nine bits wide: eight data bits plus one parity bit.

Top module: `burst_sram`

## Requirements
- R1: After reset is released, `rdrive` is low and no access is pending, so it stays low until a start strobe selects the chip.
- R2: A read started on clock edge k (chip selected, no write requested) puts the word at the presented address on `rdata` after edge k+1, with `rdrive` high while `oe_n` is low.
- R3: While `adv_n` is low on the edges after the start, each edge delivers the next beat. With `adv_n` high, the burst address is held and the same word is read again.
- R4: With `order_lin` = 1, beat n (n = 0..3) reads the address whose two low bits are (a + n) mod 4. The upper address bits never change within a burst.
- R5: With `order_lin` = 0, beat n reads the address whose two low bits are a XOR n. The upper address bits are unchanged.
- R6: A cycle with `gwr_n` low writes every lane of the word at the captured address. The write is visible to a read that starts after the write edge.
- R7: With `gwr_n` high and `bwr_en_n` low, a lane i whose `lane_wr_n[i]` is low gets `wdata[9i+8:9i]`, and the other lanes keep their contents. With both `gwr_n` and `bwr_en_n` high, the cycle is a read whatever `lane_wr_n` holds.
- R8: A start from `cpu_go_n` needs `ce_n` low. It is ignored when `ce_n` is high, and the current access carries on. A start from `cpu_go_n` is always a read, even when write controls are active.
- R9: A start strobe sampled while the chip is unselected (`ce_n` high, `cs_hi` low or `cs_lo_n` high) lets the beat already in the pipeline out on the next edge. `rdrive` is low from the edge after that.
- R10: `oe_n` high forces `rdrive` low at once, without a clock edge, and leaves `rdata` unchanged.
- R11: While `sleep` is high, `rdrive` is low and clock edges perform no write, no counter step and no new start. On the first edge after release, the access that was held resumes with the memory contents intact.
- R12: On the edge that performs a write, the output pipeline is loaded with no data, so `rdrive` is low after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the control registers |
| addr | input | AW | Word address, captured on a start |
| ce_n | input | 1 | Chip enable, active low; also gates `cpu_go_n` |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| cpu_go_n | input | 1 | Processor start strobe, active low, read-only start |
| ctl_go_n | input | 1 | Controller start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| gwr_n | input | 1 | Global write of all lanes, active low |
| bwr_en_n | input | 1 | Byte-write enable, active low |
| lane_wr_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Sleep, active high, asynchronous on the drive flag |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Registered read data |
| rdrive | output | 1 | High when `rdata` would be driven |

## Verification
A read captured on edge k shows up after edge k+1, and each later beat follows one edge after the step that produced it. The bench therefore drives inputs at the falling edge and compares `rdata` at the falling edge that follows the edge performing the read, not the one that captured the address. The drop of `rdrive` is checked twice around a deselect: still high after the capturing edge, low after the next one. It is checked once after a write edge. The effects of `oe_n` and `sleep` need no clock, so they are sampled a step after the input changes, before any edge.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  typedef enum logic {
    ORD_XOR = 1'b0,
    ORD_INC = 1'b1
  } burst_order_e;

  localparam int CNT_W = 2;

  // Low address bits of a burst beat, given the first beat's low bits.
  function automatic logic [CNT_W-1:0] beat_offset(
    input logic [CNT_W-1:0] first,
    input logic [CNT_W-1:0] beat,
    input burst_order_e     ord
  );
    if (ord == ORD_INC) return first + beat;
    return first ^ beat;
  endfunction

endpackage

// File: rtl/burst_seq.sv
module burst_seq
  import burst_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          freeze,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] load_addr,
  input  burst_order_e  order,
  output logic [AW-1:0] beat_addr
);

  logic [AW-1:0]    base_q;
  logic [CNT_W-1:0] beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (!freeze) begin
      if (load) begin
        base_q <= load_addr;
        beat_q <= '0;
      end else if (step) begin
        beat_q <= beat_q + CNT_W'(1);
      end
    end
  end

  always_comb begin
    beat_addr            = base_q;
    beat_addr[CNT_W-1:0] = beat_offset(base_q[CNT_W-1:0], beat_q, order);
  end

  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && !load && !step) |=> $stable(beat_q)); // R3

  AST_GROUP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step) |=> $stable(beat_addr[AW-1:CNT_W])); // R4

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && !load && step && order == ORD_INC) |=>
      (order != $past(order)) ||
      (beat_addr[CNT_W-1:0] == $past(beat_addr[CNT_W-1:0]) + CNT_W'(1))); // R4

  AST_FROZEN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(beat_q) && $stable(base_q)); // R11

endmodule

// File: rtl/access_ctrl.sv
module access_ctrl #(
  parameter  int AW     = 6,
  parameter  int LANES  = 2,
  parameter  int LANE_W = 9,
  localparam int DW     = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep,
  input  logic             ce_n,
  input  logic             cs_hi,
  input  logic             cs_lo_n,
  input  logic             cpu_go_n,
  input  logic             ctl_go_n,
  input  logic             adv_n,
  input  logic             gwr_n,
  input  logic             bwr_en_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic [DW-1:0]    wdata,
  output logic             load,
  output logic             step,
  output logic             act_q,
  output logic             wr_q,
  output logic [LANES-1:0] lanes_q,
  output logic [DW-1:0]    wdata_q
);

  // Which lanes a cycle writes: global write beats byte-write enable.
  function automatic logic [LANES-1:0] lane_mask(
    input logic             g_n,
    input logic             b_n,
    input logic [LANES-1:0] l_n
  );
    if (!g_n) return '1;
    if (!b_n) return ~l_n;
    return '0;
  endfunction

  logic             chip_on;
  logic             cpu_go;
  logic             ctl_go;
  logic             start_evt;
  logic             desel_evt;
  logic [LANES-1:0] wr_mask;
  logic             wr_now;

  assign chip_on   = !ce_n && cs_hi && !cs_lo_n;
  assign cpu_go    = !cpu_go_n && !ce_n;
  assign ctl_go    = !ctl_go_n;
  assign start_evt = cpu_go || ctl_go;
  assign desel_evt = start_evt && !chip_on;
  assign load      = start_evt && chip_on;
  assign step      = !start_evt && act_q && !adv_n;
  assign wr_mask   = lane_mask(gwr_n, bwr_en_n, lane_wr_n);
  assign wr_now    = (|wr_mask) && !cpu_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      wr_q    <= 1'b0;
      lanes_q <= '0;
      wdata_q <= '0;
    end else if (!sleep) begin
      if (start_evt) act_q <= chip_on;
      wr_q    <= (start_evt ? chip_on : act_q) && wr_now;
      lanes_q <= wr_mask;
      wdata_q <= wdata;
    end
  end

  AST_DESEL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (desel_evt && !sleep) |=> !act_q); // R9

  AST_CPU_START_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (load && cpu_go && !sleep) |=> !wr_q); // R8

  AST_CPU_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_go_n && ce_n && !ctl_go) |=> $stable(act_q)); // R8

  AST_SLEEP_HOLDS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(act_q) && $stable(wr_q) && $stable(lanes_q)); // R11

endmodule

// File: rtl/word_store.sv
module word_store #(
  parameter  int AW     = 6,
  parameter  int LANES  = 2,
  parameter  int LANE_W = 9,
  localparam int DW     = LANES * LANE_W,
  localparam int DEPTH  = 1 << AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze,
  input  logic             act,
  input  logic             wr,
  input  logic [LANES-1:0] lanes,
  input  logic [DW-1:0]    wdata,
  input  logic [AW-1:0]    addr,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_word
);

  logic [DW-1:0] mem [DEPTH];
  logic          do_write;
  logic          do_read;

  assign do_write = !freeze && act && wr;
  assign do_read  = !freeze && act && !wr;

  always_ff @(posedge clk) begin
    if (do_write) begin
      for (int i = 0; i < LANES; i++) begin
        if (lanes[i]) mem[addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_word  <= '0;
    end else if (!freeze) begin
      rd_valid <= do_read;
      if (do_read) rd_word <= mem[addr];
    end
  end

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    do_write |=> !rd_valid); // R12

  AST_IDLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && !act) |=> !rd_valid); // R9

  AST_FREEZE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(rd_valid) && $stable(rd_word)); // R11

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter  int AW     = 6,
  parameter  int LANES  = 2,
  parameter  int LANE_W = 9,
  localparam int DW     = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             ce_n,
  input  logic             cs_hi,
  input  logic             cs_lo_n,
  input  logic             cpu_go_n,
  input  logic             ctl_go_n,
  input  logic             adv_n,
  input  logic             order_lin,
  input  logic             gwr_n,
  input  logic             bwr_en_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             oe_n,
  input  logic             sleep,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             rdrive
);

  logic             load;
  logic             step;
  logic             act_q;
  logic             wr_q;
  logic [LANES-1:0] lanes_q;
  logic [DW-1:0]    wdata_q;
  logic [AW-1:0]    beat_addr;
  logic             rd_valid;
  burst_order_e     order;

  assign order = burst_order_e'(order_lin);

  access_ctrl #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep    (sleep),
    .ce_n     (ce_n),
    .cs_hi    (cs_hi),
    .cs_lo_n  (cs_lo_n),
    .cpu_go_n (cpu_go_n),
    .ctl_go_n (ctl_go_n),
    .adv_n    (adv_n),
    .gwr_n    (gwr_n),
    .bwr_en_n (bwr_en_n),
    .lane_wr_n(lane_wr_n),
    .wdata    (wdata),
    .load     (load),
    .step     (step),
    .act_q    (act_q),
    .wr_q     (wr_q),
    .lanes_q  (lanes_q),
    .wdata_q  (wdata_q)
  );

  burst_seq #(.AW(AW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .freeze   (sleep),
    .load     (load),
    .step     (step),
    .load_addr(addr),
    .order    (order),
    .beat_addr(beat_addr)
  );

  word_store #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .freeze  (sleep),
    .act     (act_q),
    .wr      (wr_q),
    .lanes   (lanes_q),
    .wdata   (wdata_q),
    .addr    (beat_addr),
    .rd_valid(rd_valid),
    .rd_word (rdata)
  );

  assign rdrive = rd_valid && !oe_n && !sleep;

  AST_READ_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !wr_q && !sleep) |=> rd_valid); // R2

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && wr_q && !sleep) |=> !rdrive); // R12

endmodule

// File: tb/burst_sram_test.sv
module burst_sram_test;
  localparam int AW     = 6;
  localparam int LANES  = 2;
  localparam int LANE_W = 9;
  localparam int DW     = LANES * LANE_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [AW-1:0]    addr;
  logic             ce_n, cs_hi, cs_lo_n, cpu_go_n, ctl_go_n, adv_n, order_lin;
  logic             gwr_n, bwr_en_n, oe_n, sleep;
  logic [LANES-1:0] lane_wr_n;
  logic [DW-1:0]    wdata;
  logic [DW-1:0]    rdata;
  logic             rdrive;

  logic [DW-1:0] model [1 << AW];
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  burst_sram #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .cs_hi(cs_hi),
    .cs_lo_n(cs_lo_n), .cpu_go_n(cpu_go_n), .ctl_go_n(ctl_go_n),
    .adv_n(adv_n), .order_lin(order_lin), .gwr_n(gwr_n),
    .bwr_en_n(bwr_en_n), .lane_wr_n(lane_wr_n), .oe_n(oe_n),
    .sleep(sleep), .wdata(wdata), .rdata(rdata), .rdrive(rdrive)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    addr = '0; ce_n = 0; cs_hi = 1; cs_lo_n = 0; cpu_go_n = 1; ctl_go_n = 1;
    adv_n = 1; gwr_n = 1; bwr_en_n = 1; lane_wr_n = '1; oe_n = 0; sleep = 0;
    wdata = '0;
  endtask

  task automatic write_word(input int a, input logic [DW-1:0] d);
    idle(); ctl_go_n = 0; addr = AW'(a); gwr_n = 0; wdata = d;
    tick();
    idle();
    tick();
    chk("R12", "drive after write edge", 32'(rdrive), 32'd0);
    model[a] = d;
  endtask

  task automatic read_word(input int a, input string req);
    idle(); ctl_go_n = 0; addr = AW'(a);
    tick();
    idle();
    tick();
    chk(req, "read data", 32'(rdata), 32'(model[a]));
    chk(req, "read drive", 32'(rdrive), 32'd1);
  endtask

  task automatic burst(input int a, input logic lin, input string req);
    int last;
    idle(); order_lin = lin; ctl_go_n = 0; addr = AW'(a);
    tick();
    last = a;
    for (int n = 0; n < 4; n++) begin
      int e;
      idle(); adv_n = (n < 3) ? 1'b0 : 1'b1;
      tick();
      e = lin ? ((a & ~3) | ((a + n) & 3)) : (a ^ n);
      chk(req, $sformatf("beat %0d", n), 32'(rdata), 32'(model[e]));
      last = e;
    end
    idle();
    tick();
    chk("R3", "hold with advance high", 32'(rdata), 32'(model[last]));
  endtask

  task automatic test_reset();
    idle(); order_lin = 1; rst_n = 0;
    tick(); tick();
    chk("R1", "drive during reset", 32'(rdrive), 32'd0);
    rst_n = 1;
    tick(); tick();
    chk("R1", "drive after reset", 32'(rdrive), 32'd0);
  endtask

  task automatic test_fill();
    for (int i = 0; i < 16; i++) write_word(i, DW'(32'h155 + i * 32'h4C7));
    read_word(5, "R6");
    read_word(0, "R2");
    read_word(15, "R6");
  endtask

  task automatic test_bursts();
    burst(6, 1'b1, "R4");
    burst(13, 1'b1, "R4");
    burst(13, 1'b0, "R5");
    burst(10, 1'b0, "R5");
    order_lin = 1;
  endtask

  task automatic test_lanes();
    logic [DW-1:0] old;
    old = model[3];
    idle(); ctl_go_n = 0; addr = 3; bwr_en_n = 0; lane_wr_n = 2'b10; wdata = 18'h2A5A5;
    tick(); idle(); tick();
    model[3] = {old[17:9], 9'h1A5};
    read_word(3, "R7");
    old = model[3];
    idle(); ctl_go_n = 0; addr = 3; bwr_en_n = 0; lane_wr_n = 2'b01; wdata = 18'h0F00F;
    tick(); idle(); tick();
    model[3] = {9'h078, old[8:0]};
    read_word(3, "R7");
    idle(); ctl_go_n = 0; addr = 4; bwr_en_n = 1; lane_wr_n = 2'b00; wdata = 18'h3FFFF;
    tick(); idle(); tick();
    chk("R7", "no-enable cycle reads", 32'(rdata), 32'(model[4]));
    chk("R7", "no-enable cycle drives", 32'(rdrive), 32'd1);
    read_word(4, "R7");
  endtask

  task automatic test_cpu_start();
    idle(); cpu_go_n = 0; addr = 2; gwr_n = 0; wdata = 18'h3C3C3;
    tick(); idle(); tick();
    chk("R8", "cpu start reads", 32'(rdata), 32'(model[2]));
    chk("R8", "cpu start drives", 32'(rdrive), 32'd1);
    read_word(2, "R8");
    read_word(5, "R8");
    idle(); cpu_go_n = 0; ce_n = 1; addr = 9;
    tick(); idle(); tick();
    chk("R8", "ignored cpu start keeps word", 32'(rdata), 32'(model[5]));
    chk("R8", "ignored cpu start keeps drive", 32'(rdrive), 32'd1);
  endtask

  task automatic test_deselect();
    read_word(5, "R9");
    idle(); ctl_go_n = 0; ce_n = 1;
    tick();
    chk("R9", "beat in flight still out", 32'(rdrive), 32'd1);
    idle();
    tick();
    chk("R9", "drive off after ce_n deselect", 32'(rdrive), 32'd0);
    tick();
    chk("R9", "stays off", 32'(rdrive), 32'd0);
    read_word(6, "R9");
    idle(); ctl_go_n = 0; cs_hi = 0;
    tick(); idle(); tick();
    chk("R9", "drive off after cs_hi deselect", 32'(rdrive), 32'd0);
  endtask

  task automatic test_oe();
    read_word(7, "R10");
    oe_n = 1;
    #1;
    chk("R10", "oe_n high drive", 32'(rdrive), 32'd0);
    chk("R10", "oe_n high data", 32'(rdata), 32'(model[7]));
    oe_n = 0;
    #1;
    chk("R10", "oe_n low drive", 32'(rdrive), 32'd1);
  endtask

  task automatic test_sleep();
    read_word(5, "R11");
    sleep = 1; ctl_go_n = 0; gwr_n = 0; wdata = 18'h12345; addr = 5; adv_n = 0;
    #1;
    chk("R11", "drive off in sleep", 32'(rdrive), 32'd0);
    tick(); tick();
    chk("R11", "still off in sleep", 32'(rdrive), 32'd0);
    idle();
    tick();
    chk("R11", "resume data", 32'(rdata), 32'(model[5]));
    chk("R11", "resume drive", 32'(rdrive), 32'd1);
    read_word(5, "R11");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_fill();
    test_bursts();
    test_lanes();
    test_cpu_start();
    test_deselect();
    test_oe();
    test_sleep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule